// File: doc/BRIEF.md
# Calibrated Temperature Converter with Bank Maximum

This block turns 12-bit codes from on-die thermal sensors into signed temperatures in millidegrees Celsius. The calibration constants are a gain error, a signed slope trim, a reference temperature and one offset per sensor. They are unpacked from three 32-bit fuse words. If the fuse words carry no valid calibration, fixed defaults are used. A start strobe latches the constants and clears the running maximum. It also launches two iterative divisions that produce a per-device scale factor. While those divisions run, the block reports busy.

Once busy drops, a sequencer sends one (sensor index, raw code) pair per cycle for the sensors of one bank. The last pair of the bank carries a last marker. Each accepted pair yields one converted temperature on the following cycle. A reading above 200000 is a bogus first sample, and the block replaces it with zero before it updates the bank maximum. With the last sample the block raises a done pulse, and at that point the bank maximum is final.

Top module: `thermo_calib_max`

## Requirements
- R1: Only bits [11:0] of `in_raw` take part in the conversion; bits [15:12] have no effect on any output.
- R2: With scale = ((1627604160 / (165 + slope)) / (10000 + gain)), using integer division that truncates toward zero, an accepted sample yields `out_temp` = degc·500 − ((scale · (raw − vts − 3350)) >>> 3). The result is registered one cycle after acceptance, together with `out_valid`.
- R3: When fuse0[0] is 1, the constants are decoded as follows. Gain is fuse1[31:22]. Reference temperature degc is fuse0[6:1]. Slope magnitude is fuse0[31:26]. Sensor offsets: sensor 0 is fuse0[25:17], sensor 1 is fuse0[16:8], sensor 2 is fuse1[8:0], sensor 3 is fuse2[31:23] and sensor 4 is fuse2[22:14].
- R4: When fuse0[0] is 0, the block uses gain 512, degc 40, slope 0 and offset 260 for every sensor, whatever the other fuse bits hold.
- R5: The slope is negative only when fuse0[7] and fuse1[9] are both 1; otherwise it equals the magnitude.
- R6: A converted value greater than 200000 is replaced by 0, both on `out_temp` and in the bank maximum.
- R7: `bank_max` is the signed maximum of the (clamped) samples accepted since the last accepted start. After reset, and after an accepted start before any sample, it reads 32'h80000000.
- R8: `done` is high for exactly the cycle in which `out_valid` presents the sample that was accepted with `in_last` = 1; `bank_max` already includes that sample.
- R9: `busy` is high for 64 cycles after an accepted start. `start` is accepted only while `busy` is 0, and a sample only while `busy` and `start` are both 0. A start and a sample in the same cycle accept the start and drop the sample.
- R10: Calibration constants are captured at the accepted start; later fuse changes, including during busy, do not affect conversions until the next accepted start.
- R11: Sensor indices 5 to 7 use the offset of sensor 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fuse0 | input | 32 | Fuse word 0: valid flag, degc, slope sign and magnitude, offsets of sensors 0 and 1 |
| fuse1 | input | 32 | Fuse word 1: gain, slope sign qualifier, offset of sensor 2 |
| fuse2 | input | 32 | Fuse word 2: offsets of sensors 3 and 4 |
| start | input | 1 | Latch calibration, clear maximum, compute scale |
| in_valid | input | 1 | Sample present |
| in_sensor | input | 3 | Sensor index of the sample |
| in_raw | input | 16 | Raw sensor code (low 12 bits used) |
| in_last | input | 1 | Sample is the bank's last |
| busy | output | 1 | Scale computation in progress; inputs not accepted |
| out_valid | output | 1 | Converted sample valid |
| out_temp | output | 32 | Converted, clamped temperature in millidegrees (signed) |
| bank_max | output | 32 | Running maximum of the bank (signed) |
| done | output | 1 | Last sample of the bank converted |

## Verification
A start strobe and a sample can arrive in the same cycle. Both would then write the bank maximum: the start clears it and the sample raises it. The bench drives `start` and `in_valid` together on one edge and queues no expected result for that sample. Any `out_valid` with an empty scoreboard therefore counts as a failure. After busy falls, the bench requires `bank_max` to read the cleared value. The same judgement covers samples and a second start issued during busy, while the fuse words change underneath.

// File: rtl/thermo_calib_max.sv
module thermo_calib_max #(
  parameter int LIMIT = 200000
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [31:0]        fuse0,
  input  logic [31:0]        fuse1,
  input  logic [31:0]        fuse2,
  input  logic               start,
  input  logic               in_valid,
  input  logic [2:0]         in_sensor,
  input  logic [15:0]        in_raw,
  input  logic               in_last,
  output logic               busy,
  output logic               out_valid,
  output logic signed [31:0] out_temp,
  output logic signed [31:0] bank_max,
  output logic               done
);
  localparam int NS = 5;
  localparam logic [31:0] NUMER = 32'd1627604160;
  localparam logic signed [31:0] NEG_MIN = 32'sh80000000;

  logic [9:0]        gain_d, gain_q;
  logic [5:0]        degc_d, degc_q;
  logic signed [6:0] slope_d, slope_q;
  logic [8:0]        vts_d [NS];
  logic [8:0]        vts_q [NS];

  always_comb begin
    if (fuse0[0]) begin
      gain_d  = fuse1[31:22];
      degc_d  = fuse0[6:1];
      slope_d = (fuse0[7] & fuse1[9]) ? -$signed({1'b0, fuse0[31:26]})
                                      :  $signed({1'b0, fuse0[31:26]});
      vts_d[0] = fuse0[25:17];
      vts_d[1] = fuse0[16:8];
      vts_d[2] = fuse1[8:0];
      vts_d[3] = fuse2[31:23];
      vts_d[4] = fuse2[22:14];
    end else begin
      gain_d  = 10'd512;
      degc_d  = 6'd40;
      slope_d = 7'sd0;
      for (int i = 0; i < NS; i++) vts_d[i] = 9'd260;
    end
  end

  wire unused_bits = ^{fuse1[21:10], fuse2[13:0], in_raw[15:12]};

  logic [1:0]  phase;
  logic [4:0]  cnt;
  logic [31:0] quo, rem, scale, dvs1, dvs2, dvs, rem_n, quo_n;
  logic [32:0] shifted, trial;

  assign busy    = (phase != 2'd0);
  assign dvs1    = 32'(32'sd165 + 32'(slope_q));
  assign dvs2    = 32'd10000 + {22'd0, gain_q};
  assign dvs     = (phase == 2'd1) ? dvs1 : dvs2;
  assign shifted = {rem, quo[31]};
  assign trial   = shifted - {1'b0, dvs};
  assign rem_n   = trial[32] ? shifted[31:0] : trial[31:0];
  assign quo_n   = {quo[30:0], ~trial[32]};

  logic              take_start, accept;
  logic [2:0]        sidx;
  logic signed [31:0] diff, prod, conv, clamped;

  assign take_start = start && !busy;
  assign accept     = in_valid && !busy && !start;
  assign sidx       = (in_sensor > 3'd4) ? 3'd4 : in_sensor;
  assign diff    = $signed({20'd0, in_raw[11:0]}) - $signed({23'd0, vts_q[sidx]}) - 32'sd3350;
  assign prod    = $signed(scale) * diff;
  assign conv    = $signed({26'd0, degc_q}) * 32'sd500 - (prod >>> 3);
  assign clamped = (conv > LIMIT) ? 32'sd0 : conv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= 2'd0;
      cnt       <= 5'd0;
      quo       <= 32'd0;
      rem       <= 32'd0;
      scale     <= 32'd0;
      gain_q    <= 10'd0;
      degc_q    <= 6'd0;
      slope_q   <= 7'sd0;
      for (int i = 0; i < NS; i++) vts_q[i] <= 9'd0;
      out_valid <= 1'b0;
      out_temp  <= 32'sd0;
      bank_max  <= NEG_MIN;
      done      <= 1'b0;
    end else begin
      out_valid <= accept;
      done      <= accept && in_last;
      if (accept) begin
        out_temp <= clamped;
        if (clamped > bank_max) bank_max <= clamped;
      end
      if (take_start) begin
        gain_q   <= gain_d;
        degc_q   <= degc_d;
        slope_q  <= slope_d;
        vts_q    <= vts_d;
        phase    <= 2'd1;
        cnt      <= 5'd0;
        quo      <= NUMER;
        rem      <= 32'd0;
        bank_max <= NEG_MIN;
      end else if (busy) begin
        cnt <= cnt + 5'd1;
        if (cnt == 5'd31) begin
          rem <= 32'd0;
          if (phase == 2'd1) begin
            quo   <= quo_n;
            phase <= 2'd2;
          end else begin
            scale <= quo_n;
            phase <= 2'd0;
          end
        end else begin
          rem <= rem_n;
          quo <= quo_n;
        end
      end
    end
  end
endmodule

// File: rtl/thermo_calib_max_chk.sv
module thermo_calib_max_chk (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               in_valid,
  input logic               busy,
  input logic               out_valid,
  input logic               done,
  input logic signed [31:0] out_temp,
  input logic signed [31:0] bank_max
);
  logic [6:0] run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= 7'd0;
    else        run <= busy ? run + 7'd1 : 7'd0;
  end

  // R8
  done_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> out_valid);
  // R9
  busy_drops_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && busy) |=> !out_valid);
  // R9
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R9
  busy_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run < 7'd64));
  // R7
  start_clears_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (bank_max == 32'sh80000000));
  // R6
  clamp_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_temp <= 32'sd200000));
  // R7
  max_covers_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (bank_max >= out_temp));
endmodule

bind thermo_calib_max thermo_calib_max_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .busy(busy),
  .out_valid(out_valid), .done(done), .out_temp(out_temp), .bank_max(bank_max)
);

// File: tb/thermo_calib_max_test.sv
module thermo_calib_max_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] fuse0 = '0, fuse1 = '0, fuse2 = '0;
  logic start = 1'b0, in_valid = 1'b0, in_last = 1'b0;
  logic [2:0] in_sensor = '0;
  logic [15:0] in_raw = '0;
  logic busy, out_valid, done;
  logic signed [31:0] out_temp, bank_max;

  thermo_calib_max uut (.*);

  always #10 clk = ~clk;

  int tests = 0, fails = 0;
  logic [31:0] cf0, cf1, cf2;
  int run_max;
  logic [64:0] expq [$];
  string tagq [$];
  localparam int NEG = 32'sh80000000;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model(input logic [31:0] f0, f1, f2, input int idx, input int raw);
    int gain, degc, slope, k, t;
    int vts [5];
    if (f0[0]) begin
      gain = int'(f1[31:22]); degc = int'(f0[6:1]);
      slope = int'(f0[31:26]);
      if (f0[7] && f1[9]) slope = -slope;
      vts[0] = int'(f0[25:17]); vts[1] = int'(f0[16:8]); vts[2] = int'(f1[8:0]);
      vts[3] = int'(f2[31:23]); vts[4] = int'(f2[22:14]);
    end else begin
      gain = 512; degc = 40; slope = 0;
      for (int i = 0; i < 5; i++) vts[i] = 260;
    end
    if (idx > 4) idx = 4;
    k = 1627604160 / (165 + slope);
    k = k / (10000 + gain);
    k = k * ((raw & 'hfff) - vts[idx] - 3350);
    k = k >>> 3;
    t = degc * 500 - k;
    if (t > 200000) t = 0;
    return t;
  endfunction

  function automatic logic [95:0] pack(input int gain, degc, smag, input bit sg0, sg1,
                                       input int v0, v1, v2, v3, v4);
    logic [31:0] a, b, c;
    a = {smag[5:0], v0[8:0], v1[8:0], sg0, degc[5:0], 1'b1};
    b = {gain[9:0], 12'hA5C, sg1, v2[8:0]};
    c = {v3[8:0], v4[8:0], 14'h2B3D};
    return {a, b, c};
  endfunction

  // mode 0 plain, 1 sample collides with start, 2 samples, second start and fuse change during busy
  task automatic do_start(input logic [95:0] f, input int mode, input string req);
    int n;
    @(negedge clk);
    {fuse0, fuse1, fuse2} = f;
    start = 1'b1;
    if (mode == 1) begin in_valid = 1'b1; in_sensor = 3'd0; in_raw = 16'd3610; in_last = 1'b1; end
    @(negedge clk);
    start = 1'b0; in_valid = 1'b0; in_last = 1'b0;
    {cf0, cf1, cf2} = f;
    run_max = NEG;
    n = 0;
    while (busy) begin
      if (mode == 2) begin
        in_valid = 1'b1; in_sensor = 3'd1; in_raw = 16'd3700;
        start = (n == 10);
        fuse0 = ~f[95:64]; fuse1 = 32'hFFFF_FFFF; fuse2 = 32'h1234_5678;
      end
      n++;
      @(negedge clk);
    end
    in_valid = 1'b0; start = 1'b0;
    check(n == 64, {req, " R9 busy length"}, n, 64);
    check(bank_max == NEG, {req, " R7 max cleared after start"}, bank_max, NEG);
  endtask

  task automatic send(input int idx, input int raw, input bit last, input string req);
    int t;
    t = model(cf0, cf1, cf2, idx, raw);
    if (t > run_max) run_max = t;
    expq.push_back({last, run_max[31:0], t[31:0]});
    tagq.push_back(req);
    in_valid = 1'b1; in_sensor = idx[2:0]; in_raw = raw[15:0]; in_last = last;
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (expq.size() == 0) begin
        check(1'b0, "R9 unexpected out_valid", out_temp, 0);
      end else begin
        logic [64:0] e;
        string g;
        e = expq.pop_front();
        g = tagq.pop_front();
        check(out_temp == e[31:0], {g, " temp"}, out_temp, int'(e[31:0]));
        check(bank_max == e[63:32], {g, " R7 max"}, bank_max, int'(e[63:32]));
        check(done == e[64], {g, " R8 done"}, int'(done), int'(e[64]));
      end
    end else if (rst_n && done) begin
      check(1'b0, "R8 done without out_valid", 1, 0);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [95:0] fa, fb, fc;
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && out_valid == 1'b0 && done == 1'b0, "R9 reset idle", int'(busy), 0);
    check(bank_max == NEG, "R7 reset max", bank_max, NEG);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 defaults: valid bit clear, other bits junk
    do_start({32'hFFFF_FFFE, 32'hDEAD_BEEF, 32'hCAFE_F00D}, 0, "R4");
    send(0, 3610, 1'b0, "R2 R4");
    send(2, 3000, 1'b0, "R4");
    send(4, 16'hFE10, 1'b0, "R1");
    send(3, 16'h0E10, 1'b1, "R1 R8");
    @(negedge clk);

    // R3 decoded fields, R6 bogus clamp, R11 high indices
    fa = pack(600, 45, 10, 1'b1, 1'b0, 300, 280, 320, 250, 290);
    do_start(fa, 0, "R3");
    send(0, 3700, 1'b0, "R3 R5");
    send(1, 3650, 1'b0, "R3");
    send(2, 0, 1'b0, "R6");
    send(3, 3800, 1'b0, "R3");
    send(5, 3690, 1'b0, "R11");
    send(7, 3500, 1'b1, "R11 R8");
    @(negedge clk);

    // R5 negative slope
    fb = pack(700, 50, 40, 1'b1, 1'b1, 270, 270, 270, 270, 270);
    do_start(fb, 0, "R5");
    send(0, 3800, 1'b0, "R5");
    send(4, 3400, 1'b1, "R5 R8");

    // R2 negative temperatures only, maximum stays negative
    fc = pack(400, 0, 5, 1'b0, 1'b1, 200, 200, 200, 200, 200);
    do_start(fc, 0, "R2");
    send(0, 3700, 1'b0, "R2");
    send(1, 3900, 1'b1, "R2 R8");

    // R9 R10 inputs during busy and fuse change
    do_start(fa, 2, "R10");
    send(1, 3700, 1'b0, "R10");
    send(4, 3650, 1'b1, "R10 R8");

    // R9 start and sample together: sample dropped, empty bank keeps NEG
    do_start(fb, 1, "R9 collide");
    repeat (3) @(negedge clk);
    check(bank_max == NEG, "R7 empty bank", bank_max, NEG);
    send(2, 3550, 1'b1, "R9 R8");
    repeat (3) @(negedge clk);
    check(expq.size() == 0, "R9 all results seen", expq.size(), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule